// File: doc/BRIEF.md
# Facility Data Link Coded Message Receiver

This block listens to the serial maintenance data link of a T1 line, which arrives as one bit per strobe at roughly 4 kHz. It looks for the repeating 16-bit coded-message word, takes out the 6-bit message carried inside it and keeps a short history of recent word positions. A message is taken as genuine only when it holds a clear majority of that history and is not the message already in force. Each genuinely new message is latched on the output and raises an interrupt flag that can be masked and is cleared by a register read.

The word is sent first bit first, in this order: eight ones, a zero, six message bits, and a closing zero. Once the receiver has found a word it expects the next word to start at once. It checks the next 16 bits in place and does not search again. The host sees the latched message, a flag saying that some message has been accepted since reset, and the interrupt.

Top module: `fdl_code_rx`

## Requirements
- R1: A word position is valid when its 16 bits, in order of arrival, are eight ones, a zero, six message bits and a zero. The first message bit received lands in `msg_o[5]` and the last lands in `msg_o[0]`.
- R2: While searching, every strobe tests the latest 16 bits. After a hit, the block judges each following group of exactly 16 bits as one position. A position whose fixed bits are wrong goes into the history as an invalid entry, the lock is dropped and the search starts again.
- R3: The candidate is the most recent valid message. It is accepted when at least 8 of the last 10 positions hold it. With 7 it is not accepted.
- R4: Acceptance happens only when the candidate differs from the message last accepted. After reset no message is held, so the first message that qualifies is always accepted.
- R5: On acceptance `msg_o` takes the new message and `msg_vld_o` goes high. `irq_o` is set only if `irq_mask_i` is low. A masked acceptance still latches the message.
- R6: A cycle with `irq_rd_i` high clears `irq_o`. If a set and a read fall in the same cycle, `irq_o` is set.
- R7: Reset leaves `msg_o` at 0, `msg_vld_o` low, `irq_o` low, an empty history and the receiver searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fdl_bit_i | input | 1 | Serial data link bit |
| fdl_bit_en_i | input | 1 | One-cycle strobe marking a valid bit |
| irq_mask_i | input | 1 | High blocks the interrupt from being set |
| irq_rd_i | input | 1 | Interrupt register read; clears the flag |
| msg_o | output | 6 | Last accepted message |
| msg_vld_o | output | 1 | A message has been accepted since reset |
| irq_o | output | 1 | New-message interrupt flag |

## Verification
The acceptance of a new message (which sets the flag) and the host read (which clears it) can fall in the same clock edge. The bench provokes this by raising the read strobe in the cycle right after the strobe of the closing bit of the eighth qualifying word. That is the edge at which acceptance lands. The bench passes only if the flag reads high afterwards and a later read on its own clears it.

// File: rtl/fdl_code_pkg.sv
package fdl_code_pkg;
    localparam int MSG_W    = 6;   // message field width
    localparam int ONES_W   = 8;   // leading ones of a word
    localparam int HIST_N   = 10;  // positions kept in the vote window
    localparam int VOTE_MIN = 8;   // entries needed to accept
endpackage

// File: rtl/fdl_cw_align.sv
module fdl_cw_align
    import fdl_code_pkg::*;
#(
    parameter int P_MSG_W  = MSG_W,
    parameter int P_ONES_W = ONES_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bit_i,
    input  logic               bit_en_i,
    output logic               pos_stb_o,
    output logic               pos_ok_o,
    output logic [P_MSG_W-1:0] pos_msg_o
);
    localparam int CW_W  = P_ONES_W + P_MSG_W + 2;
    localparam int CNT_W = $clog2(CW_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CW_W - 1);

    typedef struct packed {
        logic [CW_W-1:0]    sr;
        logic               lock;
        logic [CNT_W-1:0]   cnt;
        logic               stb;
        logic               ok;
        logic [P_MSG_W-1:0] msg;
    } st_t;

    st_t  st_q, st_d;
    logic hit;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        hit      = 1'b0;
        if (bit_en_i) begin
            st_d.sr = {st_q.sr[CW_W-2:0], bit_i};
            hit = (st_d.sr[CW_W-1 -: P_ONES_W] == '1)
                && !st_d.sr[P_MSG_W+1] && !st_d.sr[0];
            if (!st_q.lock) begin
                if (hit) begin
                    st_d.lock = 1'b1;
                    st_d.cnt  = '0;
                    st_d.stb  = 1'b1;
                    st_d.ok   = 1'b1;
                    st_d.msg  = st_d.sr[P_MSG_W:1];
                end
            end else if (st_q.cnt == LAST) begin
                st_d.stb  = 1'b1;
                st_d.ok   = hit;
                st_d.msg  = hit ? st_d.sr[P_MSG_W:1] : '0;
                st_d.cnt  = '0;
                st_d.lock = hit;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pos_stb_o = st_q.stb;
    assign pos_ok_o  = st_q.ok;
    assign pos_msg_o = st_q.msg;
endmodule

// File: rtl/fdl_msg_vote.sv
module fdl_msg_vote
    import fdl_code_pkg::*;
#(
    parameter int P_MSG_W    = MSG_W,
    parameter int P_HIST_N   = HIST_N,
    parameter int P_VOTE_MIN = VOTE_MIN
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pos_stb_i,
    input  logic               pos_ok_i,
    input  logic [P_MSG_W-1:0] pos_msg_i,
    output logic [P_MSG_W-1:0] acc_msg_o,
    output logic               acc_vld_o,
    output logic               acc_set_o
);
    localparam int CNT_W = $clog2(P_HIST_N + 1);

    typedef struct packed {
        logic               ok;
        logic [P_MSG_W-1:0] msg;
    } ent_t;

    typedef struct packed {
        ent_t [P_HIST_N-1:0] hist;
        logic [P_MSG_W-1:0]  cand;
        logic                cand_vld;
        logic [P_MSG_W-1:0]  acc;
        logic                acc_vld;
    } st_t;

    st_t             st_q, st_d;
    logic [CNT_W-1:0] votes;
    logic            set;

    always_comb begin
        st_d  = st_q;
        votes = '0;
        set   = 1'b0;
        if (pos_stb_i) begin
            for (int i = P_HIST_N - 1; i > 0; i--) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
            st_d.hist[0] = '{ok: pos_ok_i, msg: pos_msg_i};
            if (pos_ok_i) begin
                st_d.cand     = pos_msg_i;
                st_d.cand_vld = 1'b1;
            end
            for (int i = 0; i < P_HIST_N; i++) begin
                if (st_d.hist[i].ok && st_d.hist[i].msg == st_d.cand) begin
                    votes = votes + CNT_W'(1);
                end
            end
            if (st_d.cand_vld && votes >= CNT_W'(P_VOTE_MIN)
                && (!st_q.acc_vld || st_q.acc != st_d.cand)) begin
                set          = 1'b1;
                st_d.acc     = st_d.cand;
                st_d.acc_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign acc_msg_o = st_q.acc;
    assign acc_vld_o = st_q.acc_vld;
    assign acc_set_o = set;
endmodule

// File: rtl/fdl_irq_flag.sv
module fdl_irq_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic mask_i,
    input  logic rd_i,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rd_i)            st_d.irq = 1'b0;
        if (set_i && !mask_i) st_d.irq = 1'b1;  // set beats clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/fdl_code_rx.sv
module fdl_code_rx
    import fdl_code_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fdl_bit_i,
    input  logic             fdl_bit_en_i,
    input  logic             irq_mask_i,
    input  logic             irq_rd_i,
    output logic [MSG_W-1:0] msg_o,
    output logic             msg_vld_o,
    output logic             irq_o
);
    logic             pos_stb;
    logic             pos_ok;
    logic [MSG_W-1:0] pos_msg;
    logic             acc_set;

    fdl_cw_align #(.P_MSG_W(MSG_W), .P_ONES_W(ONES_W)) u_align (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .bit_i     (fdl_bit_i),
        .bit_en_i  (fdl_bit_en_i),
        .pos_stb_o (pos_stb),
        .pos_ok_o  (pos_ok),
        .pos_msg_o (pos_msg)
    );

    fdl_msg_vote #(.P_MSG_W(MSG_W), .P_HIST_N(HIST_N), .P_VOTE_MIN(VOTE_MIN)) u_vote (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pos_stb_i (pos_stb),
        .pos_ok_i  (pos_ok),
        .pos_msg_i (pos_msg),
        .acc_msg_o (msg_o),
        .acc_vld_o (msg_vld_o),
        .acc_set_o (acc_set)
    );

    fdl_irq_flag u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (acc_set),
        .mask_i (irq_mask_i),
        .rd_i   (irq_rd_i),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/fdl_code_rx_chk.sv
module fdl_code_rx_chk
    import fdl_code_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_mask_i,
    input logic             irq_rd_i,
    input logic [MSG_W-1:0] msg_o,
    input logic             msg_vld_o,
    input logic             irq_o,
    input logic             pos_stb,
    input logic             acc_set
);
    // R2: the latched message moves only right after a judged position
    a_r2_msg_after_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_o != $past(msg_o)) |-> $past(pos_stb));

    // R3: once a message is held it stays held until reset
    a_r3_vld_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_vld_o |=> msg_vld_o);

    // R4: a rising flag comes with a message different from the held one
    a_r4_new_differs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (!$past(msg_vld_o) || msg_o != $past(msg_o)));

    // R5: the flag never rises while masked
    a_r5_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> !$past(irq_mask_i));

    // R6: a read without a concurrent set clears the flag
    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_rd_i && !acc_set) |=> !irq_o);

    // R6: an unmasked set wins over a read in the same cycle
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_set && !irq_mask_i) |=> irq_o);
endmodule

bind fdl_code_rx fdl_code_rx_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_mask_i (irq_mask_i),
    .irq_rd_i   (irq_rd_i),
    .msg_o      (msg_o),
    .msg_vld_o  (msg_vld_o),
    .irq_o      (irq_o),
    .pos_stb    (pos_stb),
    .acc_set    (acc_set)
);

// File: tb/test_fdl_code_rx.sv
module test_fdl_code_rx;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_d = 1'b0;
    logic       bit_en = 1'b0;
    logic       mask = 1'b0;
    logic       rd = 1'b0;
    logic [5:0] msg;
    logic       vld;
    logic       irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fdl_code_rx i_fdl_code_rx (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fdl_bit_i    (bit_d),
        .fdl_bit_en_i (bit_en),
        .irq_mask_i   (mask),
        .irq_rd_i     (rd),
        .msg_o        (msg),
        .msg_vld_o    (vld),
        .irq_o        (irq)
    );

    // fields: bad | msg[6] | reps[4] | mask | exp_vld | exp_msg[6] | exp_irq
    localparam int NV = 15;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 6'h13, 4'd7,  1'b0, 1'b0, 6'h00, 1'b0},  // R3 seven is short
        {1'b0, 6'h13, 4'd1,  1'b0, 1'b1, 6'h13, 1'b1},  // R3 R4 R1 eighth accepts
        {1'b0, 6'h13, 4'd10, 1'b0, 1'b1, 6'h13, 1'b0},  // R4 same message, no flag
        {1'b0, 6'h2C, 4'd7,  1'b0, 1'b1, 6'h13, 1'b0},  // R3 7 of 10
        {1'b0, 6'h2C, 4'd1,  1'b0, 1'b1, 6'h2C, 1'b1},  // R3 8 of 10
        {1'b0, 6'h0B, 4'd8,  1'b1, 1'b1, 6'h0B, 1'b0},  // R5 masked, still latched
        {1'b0, 6'h33, 4'd8,  1'b0, 1'b1, 6'h33, 1'b1},  // R5 unmasked
        {1'b0, 6'h01, 4'd4,  1'b0, 1'b1, 6'h33, 1'b0},
        {1'b0, 6'h02, 4'd1,  1'b0, 1'b1, 6'h33, 1'b0},
        {1'b0, 6'h01, 4'd3,  1'b0, 1'b1, 6'h33, 1'b0},  // R3 interleaved, 7 votes
        {1'b0, 6'h01, 4'd1,  1'b0, 1'b1, 6'h01, 1'b1},  // R3 8 votes with a gap
        {1'b0, 6'h07, 4'd4,  1'b0, 1'b1, 6'h01, 1'b0},
        {1'b1, 6'h00, 4'd1,  1'b0, 1'b1, 6'h01, 1'b0},  // R2 broken word
        {1'b0, 6'h07, 4'd3,  1'b0, 1'b1, 6'h01, 1'b0},  // R2 invalid entry counts
        {1'b0, 6'h07, 4'd1,  1'b0, 1'b1, 6'h07, 1'b1}   // R2 relock, accept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_d  = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    // sends one 16-bit word; optionally reads in the cycle acceptance lands
    task automatic send_word(input logic bad, input logic [5:0] m, input logic rd_last);
        logic [15:0] w;
        w = bad ? 16'h0000 : {8'hFF, 1'b0, m, 1'b0};
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        if (rd_last) begin
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
        end else begin
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 msg after reset", 32'(msg), 32'h0);
        check("R7 vld after reset", 32'(vld), 32'h0);
        check("R7 irq after reset", 32'(irq), 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [19:0] v;
            v    = VEC[k];
            mask = v[8];
            for (int r = 0; r < int'(v[12:9]); r++) send_word(v[19], v[18:13], 1'b0);
            check($sformatf("R1 R3 msg row %0d", k), 32'(msg), 32'(v[6:1]));
            check($sformatf("R4 vld row %0d", k), 32'(vld), 32'(v[7]));
            check($sformatf("R5 irq row %0d", k), 32'(irq), 32'(v[0]));
            pulse_rd();
            check($sformatf("R6 irq cleared row %0d", k), 32'(irq), 32'h0);
        end
        mask = 1'b0;

        // R6 collision: read strobe lands on the acceptance edge
        for (int r = 0; r < 7; r++) send_word(1'b0, 6'h3F, 1'b0);
        check("R3 3F short of votes", 32'(msg), 32'h07);
        send_word(1'b0, 6'h3F, 1'b1);
        check("R6 set wins over read", 32'(irq), 32'h1);
        check("R1 msg 3F", 32'(msg), 32'h3F);
        pulse_rd();
        check("R6 lone read clears", 32'(irq), 32'h0);

        // R7 R4 reset mid-stream then resend the same message
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 vld after second reset", 32'(vld), 32'h0);
        check("R7 msg after second reset", 32'(msg), 32'h0);
        for (int r = 0; r < 8; r++) send_word(1'b0, 6'h3F, 1'b0);
        check("R4 first after reset accepted", 32'(msg), 32'h3F);
        check("R4 first after reset flags", 32'(irq), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule